// File: doc/BRIEF.md
# Configurable-Bias 8-bit Float to Float32 Widener

This block takes one 8-bit floating-point code and produces the exact IEEE single-precision word for the same value. A one-bit layout select chooses how the seven bits after the sign are divided. In one layout there are four exponent bits and three fraction bits. In the other there are five exponent bits and two fraction bits. A 6-bit unsigned input gives the exponent bias that applies to the code. Software can therefore move the representable window of the narrow format along the number line at run time.

The narrow formats have no infinity or NaN codes. An exponent field of all ones is an ordinary normal value. A zero exponent field holds either a signed zero or a subnormal. The subnormal scale is 2 to the power of minus the bias, which differs from IEEE practice. Every narrow value fits exactly in Float32, so the block does no rounding. A subnormal is renormalised by locating its leading one. A flag marks subnormal inputs. The block is combinational. A parameter can add one register stage at the output, and this stage is cleared by reset.

Top module: `minifloat_expander`

## Requirements
- R1: When `layout_sel` is 0, bit 7 is the sign, bits 6:3 are the exponent field and bits 2:0 are the fraction. When `layout_sel` is 1, bit 7 is the sign, bits 6:2 are the exponent and bits 1:0 are the fraction. The output sign bit 31 always equals input bit 7.
- R2: For a nonzero exponent field e, the value is 1.f × 2^(e − bias). The Float32 exponent field is e − bias + 127. The input fraction occupies the top bits of the 23-bit fraction, and every bit below it is zero.
- R3: An exponent field of all ones decodes as a normal number by the rule in R2. The output exponent field is never 255.
- R4: A zero exponent field with a zero fraction gives a zero of the input's sign. Output bits 30:0 are zero and the flag is low.
- R5: A zero exponent field with a nonzero fraction f of width w gives the value f × 2^(−bias−w). This value is written as a normalised Float32 with a nonzero exponent field, and `dnrm_out` is high.
- R6: `dnrm_out` is low for every input whose exponent field is nonzero.
- R7: Every bias from 0 to 63 is accepted. Every nonzero result has a Float32 exponent field in the range 1 to 254, with no overflow and no underflow.
- R8: With `OUT_REG` = 1, results appear one clock after their inputs, and an active-low asynchronous reset clears `f32_out` and `dnrm_out` to zero. With `OUT_REG` = 0, results follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| layout_sel | input | 1 | 0 selects the 4-bit exponent / 3-bit fraction layout; 1 selects the 5-bit exponent / 2-bit fraction layout |
| bias_in | input | 6 | Unsigned exponent bias, 0 to 63 |
| code_in | input | 8 | Narrow floating-point code |
| f32_out | output | 32 | Exact IEEE single-precision result |
| dnrm_out | output | 1 | High when the input is a subnormal |

## Verification
The registered instance delivers `f32_out` and `dnrm_out` one rising edge after the inputs are applied. The combinational instance delivers them in the same cycle. The bench drives each vector on a falling edge and checks both instances on the next falling edge. By then the register has captured the vector, and the combinational path has settled on the same inputs, which are still held. The bench sweeps both layouts, all 64 bias values and all 256 codes. For the registered instance, it checks the cleared outputs while reset is held.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

    localparam int CODE_W   = 8;
    localparam int BIAS_W   = 6;

    // layout with the wider fraction
    localparam int LA_EW    = 4;
    localparam int LA_MW    = 3;
    // layout with the wider exponent
    localparam int LB_EW    = 5;
    localparam int LB_MW    = 2;

    // common carrier widths: widest exponent, widest fraction
    localparam int EXP_W    = LB_EW;
    localparam int MANT_W   = LA_MW;
    localparam int LZ_W     = $clog2(MANT_W + 1);

    localparam int F32_W    = 32;
    localparam int F32_EW   = 8;
    localparam int F32_FW   = 23;
    localparam int F32_BIAS = 127;
    localparam int PAD_W    = F32_FW - MANT_W;

    typedef enum logic {
        LAYOUT_WIDE_FRAC = 1'b0,
        LAYOUT_WIDE_EXP  = 1'b1
    } layout_e;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] frac;   // MSB-aligned fraction
        logic              exp_zero;
        logic              frac_zero;
    } fields_t;

endpackage

// File: rtl/mfx_unpack.sv
module mfx_unpack
    import mfx_pkg::*;
(
    input  layout_e           mode,
    input  logic [CODE_W-1:0] code,
    output fields_t           fld
);

    always_comb begin
        fld     = '0;
        fld.sgn = code[CODE_W-1];
        unique case (mode)
            LAYOUT_WIDE_FRAC: begin
                fld.expo = EXP_W'(code[CODE_W-2 -: LA_EW]);
                fld.frac = MANT_W'(code[LA_MW-1:0]);
            end
            LAYOUT_WIDE_EXP: begin
                fld.expo = EXP_W'(code[CODE_W-2 -: LB_EW]);
                fld.frac = MANT_W'(code[LB_MW-1:0]) << (MANT_W - LB_MW);
            end
            default: begin
                fld.expo = '0;
                fld.frac = '0;
            end
        endcase
        fld.exp_zero  = (fld.expo == '0);
        fld.frac_zero = (fld.frac == '0);
    end

endmodule

// File: rtl/mfx_lzc.sv
module mfx_lzc #(
    parameter int W  = 3,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] lead_zeros
);

    // scan upward; the highest set bit is the last to write
    always_comb begin
        lead_zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                lead_zeros = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/mfx_pack.sv
module mfx_pack
    import mfx_pkg::*;
(
    input  fields_t           fld,
    input  logic [BIAS_W-1:0] bias,
    input  logic [LZ_W-1:0]   lz,
    output logic [F32_W-1:0]  word,
    output logic              dnrm
);

    logic [F32_EW-1:0] exp_norm;
    logic [F32_EW-1:0] exp_sub;
    logic [MANT_W-1:0] frac_sub;

    // results stay in 1..254, so modulo-256 arithmetic is exact
    assign exp_norm = F32_EW'(fld.expo) - F32_EW'(bias) + F32_EW'(F32_BIAS);
    assign exp_sub  = F32_EW'(F32_BIAS) - F32_EW'(bias) - F32_EW'(lz) - F32_EW'(1);
    // drop the leading one: shift by lz+1 and keep the low bits
    assign frac_sub = MANT_W'({fld.frac, 1'b0} << lz);

    always_comb begin
        unique case ({fld.exp_zero, fld.frac_zero})
            2'b11: begin
                word = {fld.sgn, {(F32_W-1){1'b0}}};
                dnrm = 1'b0;
            end
            2'b10: begin
                word = {fld.sgn, exp_sub, frac_sub, {PAD_W{1'b0}}};
                dnrm = 1'b1;
            end
            default: begin
                word = {fld.sgn, exp_norm, fld.frac, {PAD_W{1'b0}}};
                dnrm = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/minifloat_expander.sv
module minifloat_expander
    import mfx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              layout_sel,
    input  logic [BIAS_W-1:0] bias_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [F32_W-1:0]  f32_out,
    output logic              dnrm_out
);

    fields_t           fld;
    logic [LZ_W-1:0]   lz;
    logic [F32_W-1:0]  word_c;
    logic              dnrm_c;

    mfx_unpack u_unpack (
        .mode (layout_e'(layout_sel)),
        .code (code_in),
        .fld  (fld)
    );

    mfx_lzc #(.W(MANT_W)) u_lzc (
        .vec        (fld.frac),
        .lead_zeros (lz)
    );

    mfx_pack u_pack (
        .fld  (fld),
        .bias (bias_in),
        .lz   (lz),
        .word (word_c),
        .dnrm (dnrm_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    f32_out  <= '0;
                    dnrm_out <= 1'b0;
                end else begin
                    f32_out  <= word_c;
                    dnrm_out <= dnrm_c;
                end
            end
        end else begin : g_comb
            assign f32_out  = word_c;
            assign dnrm_out = dnrm_c;
        end
    endgenerate

endmodule

// File: rtl/mfx_chk.sv
module mfx_chk
    import mfx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              layout_sel,
    input logic [BIAS_W-1:0] bias_in,
    input logic [CODE_W-1:0] code_in,
    input logic [F32_W-1:0]  f32_out,
    input logic              dnrm_out
);

    logic              armed;
    logic              c_sel;
    logic [BIAS_W-1:0] c_bias;
    logic [CODE_W-1:0] c_code;
    logic              c_ez;
    logic              c_fz;
    logic [8:0]        oexp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    generate
        if (OUT_REG) begin : g_lag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    c_sel  <= 1'b0;
                    c_bias <= '0;
                    c_code <= '0;
                end else begin
                    c_sel  <= layout_sel;
                    c_bias <= bias_in;
                    c_code <= code_in;
                end
            end
        end else begin : g_now
            assign c_sel  = layout_sel;
            assign c_bias = bias_in;
            assign c_code = code_in;
        end
    endgenerate

    assign c_ez = c_sel ? (c_code[6:2] == 5'd0) : (c_code[6:3] == 4'd0);
    assign c_fz = c_sel ? (c_code[1:0] == 2'd0) : (c_code[2:0] == 3'd0);
    assign oexp = {1'b0, f32_out[30:23]};

    AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!armed) f32_out[31] == c_code[7]); // R1
    AST_NORMAL_WINDOW: assert property (@(posedge clk) disable iff (!armed) !c_ez |-> (oexp >= 9'd128 - 9'(c_bias)) && (f32_out[19:0] == 20'd0)); // R2
    AST_NO_SPECIAL: assert property (@(posedge clk) disable iff (!armed) f32_out[30:23] != 8'hFF); // R3
    AST_ZERO_SIGNED: assert property (@(posedge clk) disable iff (!armed) (c_ez && c_fz) |-> (f32_out[30:0] == 31'd0) && !dnrm_out); // R4
    AST_SUB_BELOW: assert property (@(posedge clk) disable iff (!armed) dnrm_out |-> (oexp < 9'd127 - 9'(c_bias)) && (oexp != 9'd0)); // R5
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!armed) !c_ez |-> !dnrm_out); // R6

endmodule

bind minifloat_expander mfx_chk #(.OUT_REG(OUT_REG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .layout_sel (layout_sel),
    .bias_in    (bias_in),
    .code_in    (code_in),
    .f32_out    (f32_out),
    .dnrm_out   (dnrm_out)
);

// File: tb/minifloat_expander_tb_top.sv
`timescale 1ns/1ps
module minifloat_expander_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        layout_sel = 1'b0;
    logic [5:0]  bias_in = '0;
    logic [7:0]  code_in = '0;
    logic [31:0] f32_reg, f32_cmb;
    logic        dn_reg, dn_cmb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    minifloat_expander #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel), .bias_in(bias_in),
        .code_in(code_in), .f32_out(f32_reg), .dnrm_out(dn_reg)
    );

    minifloat_expander #(.OUT_REG(1'b0)) comb_i (
        .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel), .bias_in(bias_in),
        .code_in(code_in), .f32_out(f32_cmb), .dnrm_out(dn_cmb)
    );

    // independent model: value = M * 2^E, then normalise to 1.x
    function automatic logic [31:0] model(input bit sel, input int bias, input int code,
                                          output bit dn);
        int ew, mw, e, m, s, mag, ex, k, ef, fr;
        ew = sel ? 5 : 4;
        mw = sel ? 2 : 3;
        e  = (code >> mw) & ((1 << ew) - 1);
        m  = code & ((1 << mw) - 1);
        s  = (code >> 7) & 1;
        dn = (e == 0) && (m != 0);
        if (e == 0 && m == 0) return {s[0], 31'd0};
        mag = (e == 0) ? m : ((1 << mw) | m);
        ex  = ((e == 0) ? -bias : (e - bias)) - mw;
        k   = 0;
        for (int i = 0; i < 8; i++) if (((mag >> i) & 1) == 1) k = i;
        ef  = ex + k + 127;
        fr  = (mag << (23 - k)) & 32'h7F_FFFF;
        return {s[0], ef[7:0], fr[22:0]};
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h (sel=%0d bias=%0d code=%02h)",
                     tag, act, exp, layout_sel, bias_in, code_in);
        end
    endtask

    task automatic report;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (120000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8: actual timeout expected completion");
            report();
        end
    end

    initial begin : stim
        logic [31:0] exp_w;
        bit          exp_dn;
        string       tag;
        int          e_all;

        // R8: reset clears the registered outputs, input nonzero
        code_in = 8'h5A;
        bias_in = 6'd9;
        repeat (3) @(negedge clk);
        check_val("R8 reset word", f32_reg, 32'd0);
        check_val("R8 reset flag", {31'd0, dn_reg}, 32'd0);
        rst_n = 1'b1;

        for (int sel = 0; sel < 2; sel++) begin
            for (int b = 0; b < 64; b++) begin
                for (int c = 0; c < 256; c++) begin
                    layout_sel = sel[0];
                    bias_in    = b[5:0];
                    code_in    = c[7:0];
                    @(negedge clk);
                    exp_w = model(sel[0], b, c, exp_dn);
                    e_all = sel ? ((c >> 2) & 31) : ((c >> 3) & 15);
                    if (exp_w[30:0] == 31'd0)            tag = "R1 R4 zero";
                    else if (exp_dn)                     tag = "R1 R5 subnormal";
                    else if (e_all == (sel ? 31 : 15))   tag = "R1 R3 top exponent";
                    else                                 tag = "R1 R2 normal";
                    check_val(tag, f32_reg, exp_w);
                    check_val(exp_dn ? "R5 flag" : "R6 flag", {31'd0, dn_reg}, {31'd0, exp_dn});
                    check_val("R8 same-cycle word", f32_cmb, exp_w);
                    check_val("R8 same-cycle flag", {31'd0, dn_cmb}, {31'd0, exp_dn});
                    if (f32_reg[30:0] != 31'd0) begin
                        checks++;
                        if (f32_reg[30:23] == 8'd0 || f32_reg[30:23] == 8'hFF) begin
                            errors++;
                            $display("FAIL R7 exponent range: actual %0d expected 1..254",
                                     f32_reg[30:23]);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        report();
    end

endmodule